// File: doc/BRIEF.md
# Serial EEPROM Slave with Two-Wire Bus

This block is the slave side of a two-wire serial memory. It holds 512 bytes, split into two blocks of 256 bytes each. All of its logic runs on a system clock. The two bus lines come in as plain inputs. The block pulls the data line low through a single open-drain enable output. A master reaches it with a device-select byte. The upper nibble of that byte is a fixed identification code, two bits must match the chip-select pins, one bit chooses the block, and the lowest bit gives the transfer direction.

Two transfers are supported. A byte write sends a select, then an address, then a data byte, and a STOP commits the byte. A random read is a dummy write that loads the address, followed by a repeated START and a read select. The block then shifts the addressed byte out, most significant bit first.

After a committed write the block goes busy for a set number of system clocks, which stands in for the internal programming time. While busy it ignores the bus entirely. A single address counter is shared by reads and writes. It advances after every byte that is read or written, so a read select that has no dummy write in front of it returns the byte after the last one accessed.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0. The block waits for a START, and it never pulls the data line while it is idle.
- R2: The block acknowledges a device-select byte only when bits 7:4 equal 4'b1010 and bits 3:2 equal `chip_sel_i`. To acknowledge, it pulls SDA low for the whole 9th clock. On a mismatch it gives no acknowledge and ignores the bus until the next START.
- R3: Incoming bits are sampled on the rising edge of SCL, most significant bit first. The block changes its SDA drive only while SCL is low.
- R4: A byte write is a select with bit 0 = 0, an address byte and a data byte, and each of the three is acknowledged. The STOP that follows stores the data at that address in the block chosen by bit 1 of the select.
- R5: For BUSY_CLKS system clocks after the STOP that commits a write, the block acknowledges no select and drives nothing. Once that window ends it acknowledges a matching select again.
- R6: A random read works as follows. A write select and an address byte load the address. Then a repeated START and a select with bit 0 = 1 are acknowledged, and the block shifts out the byte stored at that address in the block chosen by bit 1, most significant bit first.
- R7: The address counter increases by one, wrapping from 255 to 0, after each byte written or read. A read select sent with no dummy write returns the byte at the counter.
- R8: A STOP seen while a byte is being shifted out, or during the master's acknowledge bit, is ignored: the remaining bits are still driven. A NACK from the master followed by a STOP returns the block to idle.
- R9: A START that arrives after the data byte of a write, instead of a STOP, abandons the write. Memory is left unchanged and no busy window starts.
- R10: The two blocks are separate storage. The same address in block 0 and in block 1 holds independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_sel_i | input | 2 | Chip-select value compared with select bits 3:2 |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, read back from the bus |
| sda_oe_o | output | 1 | When 1, pulls the data line low |

## Verification
Select bytes are tried with a wrong chip-select and with a wrong identification code. These show whether the acknowledge really depends on both fields. Writes to the same address in both blocks, and a write to address 255 followed by a current-address read, separate block selection from counter wrap-around. Writes are sent during the busy window and just after it. Writes are also abandoned with a START, and a STOP is forced in the middle of a read byte whose tail bits are zero. Each of these can only end one way on a correct design. A fixed-seed random run of writes, read back in reverse order, covers general data patterns and last-write-wins behaviour.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK, ST_WDAT, ST_WDAT_ACK,
    ST_WSTOP, ST_TX, ST_RACK, ST_RWAIT, ST_BUSY
  } st_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;   // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/eep_cond.sv
module eep_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edge while clock stays high
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BUSY_CLKS   = 1000000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DEPTH      = 2 << ADDR_W,
  localparam int unsigned MEM_AW     = ADDR_W + 1,
  localparam int unsigned BUSY_W     = $clog2(BUSY_CLKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] chip_sel_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start, stop;

  eep_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  eep_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  st_e               st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              blk_q, rw_q;
  logic [BUSY_W-1:0] busy_q;
  logic              mem_we;
  logic [BYTE_W-1:0] rd_data;
  logic              sel_hit;
  logic              stop_live;

  assign sel_hit   = (sh_q[7:4] == DEV_CODE) && (sh_q[3:2] == chip_sel_i);
  assign mem_we    = (st_q == ST_WSTOP) && stop;
  // a STOP cannot end a read before the master's acknowledge bit is done
  assign stop_live = stop && (st_q != ST_TX) && (st_q != ST_RACK);

  eep_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i({blk_q, addr_q}),
    .wdata_i(wdat_q),
    .raddr_i({blk_q, addr_q}),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      wdat_q <= '0;
      addr_q <= '0;
      blk_q  <= 1'b0;
      rw_q   <= 1'b0;
      busy_q <= '0;
    end else if (st_q == ST_BUSY) begin
      if (busy_q == '0) st_q <= ST_IDLE;
      else              busy_q <= busy_q - 1'b1;
    end else if (start) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
    end else if (stop_live) begin
      if (st_q == ST_WSTOP) begin
        addr_q <= addr_q + 1'b1;
        busy_q <= BUSY_W'(BUSY_CLKS - 1);
        st_q   <= ST_BUSY;
      end else begin
        st_q <= ST_IDLE;
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_q <= '0;
            if (st_q == ST_DEV) begin
              if (sel_hit) begin
                blk_q <= sh_q[1];
                rw_q  <= sh_q[0];
                st_q  <= ST_DEV_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_ADDR) begin
              addr_q <= sh_q[ADDR_W-1:0];
              st_q   <= ST_ADDR_ACK;
            end else begin
              wdat_q <= sh_q;
              st_q   <= ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q <= rd_data;
              st_q <= ST_TX;
            end else begin
              st_q <= ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) st_q <= ST_WDAT;
        ST_WDAT_ACK: if (scl_fall) st_q <= ST_WSTOP;
        ST_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_RACK;
            end else begin
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: if (scl_rise) st_q <= ST_RWAIT;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_DEV_ACK, ST_ADDR_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
      ST_TX:                                sda_oe_o = ~tx_q[BYTE_W-1];
      default:                              sda_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              sda_oe_i,
  input st_e               st_i,
  input logic [7:0]        sh_i,
  input logic [1:0]        chip_sel_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] addr_i
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_oe_i);

  p_ack_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DEV_ACK) |-> (sh_i[7:4] == 4'b1010 && sh_i[3:2] == chip_sel_i));

  p_drive_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  p_commit_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (st_i == ST_BUSY));

  p_busy_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_BUSY) |-> !sda_oe_i);

  p_addr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (addr_i == ADDR_W'($past(addr_i) + 1'b1)));
endmodule

bind i2c_eeprom_slave eep_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s_i   (scl_s),
  .sda_oe_i  (sda_oe_o),
  .st_i      (st_q),
  .sh_i      (sh_q),
  .chip_sel_i(chip_sel_i),
  .mem_we_i  (mem_we),
  .addr_i    (addr_q)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
  localparam int BUSY = 1500;
  localparam int Q    = 8;
  localparam logic [1:0] CS = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave #(.BUSY_CLKS(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chip_sel_i(CS),
    .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ref_mem [512];
  logic [7:0] ref_addr;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tq(Q); scl = 1'b1; tq(Q); m_sda = 1'b0; tq(Q); scl = 1'b0; tq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq(Q); scl = 1'b1; tq(Q); m_sda = 1'b1; tq(Q);
  endtask

  task automatic send_bit(bit b);
    m_sda = b; tq(Q); scl = 1'b1; tq(2*Q); scl = 1'b0; tq(Q);
  endtask

  task automatic read_bit(output bit b);
    m_sda = 1'b1; tq(Q); scl = 1'b1; tq(Q); b = sda_bus; tq(Q); scl = 1'b0; tq(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(output logic [7:0] v, input bit nack);
    bit b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
    send_bit(nack);
  endtask

  function automatic logic [7:0] sel(bit blk, bit rw);
    return {4'b1010, CS, blk, rw};
  endfunction

  task automatic do_write(bit blk, logic [7:0] a, logic [7:0] d, bit wait_busy);
    bit ack;
    bus_start();
    send_byte(sel(blk, 1'b0), ack); chk(ack, "R4 select ack", ack, 1);
    send_byte(a, ack);              chk(ack, "R4 address ack", ack, 1);
    send_byte(d, ack);              chk(ack, "R4 data ack", ack, 1);
    bus_stop();
    ref_mem[{blk, a}] = d;
    ref_addr = a + 8'd1;
    if (wait_busy) tq(BUSY + 50);
  endtask

  task automatic do_read(bit blk, logic [7:0] a, output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte(sel(blk, 1'b0), ack); chk(ack, "R6 dummy select ack", ack, 1);
    send_byte(a, ack);              chk(ack, "R6 address ack", ack, 1);
    bus_start();
    send_byte(sel(blk, 1'b1), ack); chk(ack, "R6 read select ack", ack, 1);
    read_byte(d, 1'b1);
    bus_stop();
    ref_addr = a + 8'd1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack, b;
    logic [7:0] d;
    logic [7:0] wa [12];
    bit wb [12];
    void'($urandom(32'h5eed_1234));
    tq(6); rst_n = 1'b1; tq(6);
    chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

    // R2: wrong chip select, then a further byte is ignored
    bus_start();
    send_byte({4'b1010, ~CS, 2'b00}, ack); chk(!ack, "R2 chip-select mismatch", ack, 0);
    send_byte(8'h00, ack);                 chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, CS, 2'b00}, ack);  chk(!ack, "R2 code mismatch", ack, 0);
    bus_stop();

    // R10: same address, both blocks
    do_write(1'b0, 8'h3C, 8'h5A, 1'b1);
    do_write(1'b1, 8'h3C, 8'hA5, 1'b1);
    do_read(1'b0, 8'h3C, d); chk(d == 8'h5A, "R10 block0 data", d, 8'h5A);
    do_read(1'b1, 8'h3C, d); chk(d == 8'hA5, "R10 block1 data", d, 8'hA5);

    // R5: busy window
    do_write(1'b0, 8'h10, 8'h77, 1'b0);
    tq(10);
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk(!ack, "R5 no ack right after write", ack, 0);
    tq(BUSY / 2);
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk(!ack, "R5 no ack mid busy", ack, 0);
    tq(BUSY);
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk(ack, "R5 ack after busy", ack, 1);

    // R9: START instead of STOP abandons write
    bus_start();
    send_byte(sel(1'b0, 1'b0), ack); send_byte(8'h10, ack); send_byte(8'h11, ack);
    bus_start(); bus_stop();
    bus_start(); send_byte(sel(1'b0, 1'b0), ack); bus_stop();
    chk(ack, "R9 not busy after abandon", ack, 1);
    do_read(1'b0, 8'h10, d); chk(d == 8'h77, "R9 memory unchanged", d, 8'h77);

    // R7 wrap: write 0xFF then current-address read returns address 0
    do_write(1'b0, 8'h00, 8'hC3, 1'b1);
    do_write(1'b0, 8'hFF, 8'h99, 1'b1);
    bus_start(); send_byte(sel(1'b0, 1'b1), ack); read_byte(d, 1'b1); bus_stop();
    chk(d == 8'hC3, "R7 counter wrap after write", d, 8'hC3);

    // R8: STOP during read byte 0xF0 is ignored; tail zeros still driven
    do_write(1'b1, 8'h81, 8'h3E, 1'b1);
    do_write(1'b1, 8'h80, 8'hF0, 1'b1);
    bus_start();
    send_byte(sel(1'b1, 1'b0), ack); send_byte(8'h80, ack);
    bus_start();
    send_byte(sel(1'b1, 1'b1), ack); chk(ack, "R6 read select ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      read_bit(b); chk(b == 1'b1, "R6 high bits msb first", b, 1);
    end
    m_sda = 1'b0; tq(Q); scl = 1'b1; tq(Q); m_sda = 1'b1; tq(Q); scl = 1'b0; tq(Q);
    for (int i = 0; i < 4; i++) begin
      read_bit(b); chk(b == 1'b0, "R8 bits after ignored stop", b, 0);
    end
    send_bit(1'b1);
    bus_stop();
    tq(4);
    chk(sda_oe == 1'b0, "R8 idle after nack and stop", sda_oe, 0);
    // R7: current read after byte read
    bus_start(); send_byte(sel(1'b1, 1'b1), ack); read_byte(d, 1'b1); bus_stop();
    chk(d == 8'h3E, "R7 counter after read", d, 8'h3E);

    // random writes, read back in reverse (R4, R6, R3)
    for (int i = 0; i < 12; i++) begin
      wb[i] = 1'($urandom % 2);
      wa[i] = 8'($urandom % 32);
      do_write(wb[i], wa[i], 8'($urandom), 1'b1);
    end
    for (int i = 11; i >= 0; i--) begin
      do_read(wb[i], wa[i], d);
      chk(d == ref_mem[{wb[i], wa[i]}], "R4 R6 random readback", d, ref_mem[{wb[i], wa[i]}]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule